// File: doc/BRIEF.md
# Macro Code Upload Collector

This block sits on the method-write path of a command processor and intercepts macro program uploads. Each incoming write carries a method number, a 32-bit value and a count of the parameters still to come in the same burst. A select method names the macro entry that is about to be loaded and restarts the word index. An append method supplies the next code word. Every accepted word is passed straight to a code-memory write port, addressed by entry and word index. The word whose remaining count is zero closes the upload. At that point the block raises a commit strobe with the entry and the word count, then marks the entry invalid.

Writes to any other method, including the reserved code method 0x45, go to the engine path unchanged in the same cycle. The two upload methods are absorbed and never forwarded. Words past the buffer depth are discarded and set a sticky overflow flag. Append words that arrive with no valid entry are dropped and set a sticky orphan flag.

Top module: `macro_upload_collector`

## Requirements
- R1: After reset, code_we, commit_valid, overflow_flag and orphan_flag are 0, and the current entry is invalid. An append before any select is therefore treated as an orphan.
- R2: A write to method 0x47 (select) makes its value the current entry and restarts the word index at 0. It produces no code write and no commit.
- R3: A write to method 0x46 (append) with a valid entry and room in the buffer drives one code write on the next cycle. That write carries code_entry = current entry, code_addr = word index and code_data = written value, and the index then advances by one.
- R4: An append whose remaining count is 0 raises commit_valid for exactly one cycle, on the same cycle as its code write. commit_entry holds the current entry and commit_count holds the number of words accepted, including that last word.
- R5: After a commit the current entry becomes the invalid value 0xFFFFFFFF. A following append without a new select produces no code write and no commit.
- R6: Methods 0x46 and 0x47 are never forwarded. Every other method, including 0x45, appears on fwd_valid, fwd_method, fwd_value and fwd_remaining unchanged in the same cycle and has no effect on the upload state.
- R7: The buffer holds 64 words. An append beyond the 64th produces no code write and sets overflow_flag, which stays 1 until reset. commit_count then reports 64.
- R8: An append while the entry is invalid sets orphan_flag, which stays 1 until reset.
- R9: A select that arrives in the middle of a burst drops the words counted so far. The next append writes index 0 under the new entry, and a commit reports only the words since that select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Method write present |
| in_method | input | 12 | Method number |
| in_value | input | 32 | Written value |
| in_remaining | input | 8 | Parameters still to follow in this burst |
| fwd_valid | output | 1 | Forwarded write present |
| fwd_method | output | 12 | Forwarded method number |
| fwd_value | output | 32 | Forwarded value |
| fwd_remaining | output | 8 | Forwarded remaining count |
| code_we | output | 1 | Code memory write enable |
| code_entry | output | 32 | Macro entry of the code write |
| code_addr | output | 6 | Word index within the entry |
| code_data | output | 32 | Code word |
| commit_valid | output | 1 | Single-cycle commit strobe |
| commit_entry | output | 32 | Entry being committed |
| commit_count | output | 7 | Number of words committed |
| overflow_flag | output | 1 | Sticky: a word past the buffer depth was dropped |
| orphan_flag | output | 1 | Sticky: an append arrived with no valid entry |

## Verification
The bench targets single-word bursts, a re-select in the middle of a burst, an append directly after a commit, and a 70-word burst that runs past the 64-word depth. A design that failed to invalidate the entry would write the orphan word into the old entry. A design that failed to restart the index would write the new entry at a stale address. A design without saturation would wrap code_addr to 0 and report a count of 70 or 6 instead of 64. Forwarding checks on the reserved method 0x45 and on an ordinary method catch a decoder that swallows too much or too little.

// File: rtl/muc_pkg.sv
package muc_pkg;

    localparam int MUC_METHOD_W = 12;
    localparam int MUC_DATA_W   = 32;
    localparam int MUC_REM_W    = 8;
    localparam int MUC_DEPTH    = 64;

    localparam logic [MUC_METHOD_W-1:0] MUC_SELECT_METHOD = 12'h047;
    localparam logic [MUC_METHOD_W-1:0] MUC_APPEND_METHOD = 12'h046;

    // Decoded class of a method write.
    typedef enum logic [1:0] {
        KIND_OTHER  = 2'd0,
        KIND_SELECT = 2'd1,
        KIND_APPEND = 2'd2
    } muc_kind_e;

    function automatic logic muc_consumed(input muc_kind_e k);
        return (k == KIND_SELECT) || (k == KIND_APPEND);
    endfunction

endpackage

// File: rtl/muc_decode.sv
module muc_decode
    import muc_pkg::*;
#(
    parameter int                    METHOD_W      = MUC_METHOD_W,
    parameter logic [METHOD_W-1:0]   SELECT_METHOD = MUC_SELECT_METHOD,
    parameter logic [METHOD_W-1:0]   APPEND_METHOD = MUC_APPEND_METHOD
) (
    input  logic                in_valid,
    input  logic [METHOD_W-1:0] in_method,
    output muc_kind_e           kind,
    output logic                consume
);
    always_comb begin
        kind = KIND_OTHER;
        if (in_valid) begin
            if (in_method == SELECT_METHOD)      kind = KIND_SELECT;
            else if (in_method == APPEND_METHOD) kind = KIND_APPEND;
        end
        consume = muc_consumed(kind);
    end
endmodule

// File: rtl/muc_collect.sv
module muc_collect
    import muc_pkg::*;
#(
    parameter int DATA_W = MUC_DATA_W,
    parameter int REM_W  = MUC_REM_W,
    parameter int DEPTH  = MUC_DEPTH,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  muc_kind_e         kind,
    input  logic [DATA_W-1:0] value,
    input  logic [REM_W-1:0]  remaining,
    output logic              code_we,
    output logic [DATA_W-1:0] code_entry,
    output logic [IDX_W-1:0]  code_addr,
    output logic [DATA_W-1:0] code_data,
    output logic              commit_valid,
    output logic [DATA_W-1:0] commit_entry,
    output logic [CNT_W-1:0]  commit_count,
    output logic              overflow_flag,
    output logic              orphan_flag
);
    localparam logic [DATA_W-1:0] INVALID_ENTRY = '1;

    logic [DATA_W-1:0] entry_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              entry_ok;
    logic              room;
    logic              last;
    logic [CNT_W-1:0]  cnt_next;

    always_comb begin
        entry_ok = (entry_q != INVALID_ENTRY);
        room     = (cnt_q < CNT_W'(DEPTH));
        last     = (remaining == '0);
        cnt_next = room ? cnt_q + CNT_W'(1) : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q       <= INVALID_ENTRY;
            cnt_q         <= '0;
            code_we       <= 1'b0;
            code_entry    <= '0;
            code_addr     <= '0;
            code_data     <= '0;
            commit_valid  <= 1'b0;
            commit_entry  <= '0;
            commit_count  <= '0;
            overflow_flag <= 1'b0;
            orphan_flag   <= 1'b0;
        end else begin
            code_we      <= 1'b0;
            commit_valid <= 1'b0;
            if (kind == KIND_SELECT) begin
                entry_q <= value;
                cnt_q   <= '0;
            end else if (kind == KIND_APPEND) begin
                if (!entry_ok) begin
                    orphan_flag <= 1'b1;
                end else begin
                    if (room) begin
                        code_we    <= 1'b1;
                        code_entry <= entry_q;
                        code_addr  <= cnt_q[IDX_W-1:0];
                        code_data  <= value;
                    end else begin
                        overflow_flag <= 1'b1;
                    end
                    if (last) begin
                        commit_valid <= 1'b1;
                        commit_entry <= entry_q;
                        commit_count <= cnt_next;
                        entry_q      <= INVALID_ENTRY;
                        cnt_q        <= '0;
                    end else begin
                        cnt_q <= cnt_next;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/macro_upload_collector.sv
module macro_upload_collector
    import muc_pkg::*;
#(
    parameter int                  METHOD_W      = MUC_METHOD_W,
    parameter int                  DATA_W        = MUC_DATA_W,
    parameter int                  REM_W         = MUC_REM_W,
    parameter int                  DEPTH         = MUC_DEPTH,
    parameter logic [METHOD_W-1:0] SELECT_METHOD = MUC_SELECT_METHOD,
    parameter logic [METHOD_W-1:0] APPEND_METHOD = MUC_APPEND_METHOD,
    localparam int                 IDX_W         = $clog2(DEPTH),
    localparam int                 CNT_W         = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [METHOD_W-1:0] in_method,
    input  logic [DATA_W-1:0]   in_value,
    input  logic [REM_W-1:0]    in_remaining,
    output logic                fwd_valid,
    output logic [METHOD_W-1:0] fwd_method,
    output logic [DATA_W-1:0]   fwd_value,
    output logic [REM_W-1:0]    fwd_remaining,
    output logic                code_we,
    output logic [DATA_W-1:0]   code_entry,
    output logic [IDX_W-1:0]    code_addr,
    output logic [DATA_W-1:0]   code_data,
    output logic                commit_valid,
    output logic [DATA_W-1:0]   commit_entry,
    output logic [CNT_W-1:0]    commit_count,
    output logic                overflow_flag,
    output logic                orphan_flag
);
    muc_kind_e kind;
    logic      consume;

    muc_decode #(
        .METHOD_W      (METHOD_W),
        .SELECT_METHOD (SELECT_METHOD),
        .APPEND_METHOD (APPEND_METHOD)
    ) decode_i (
        .in_valid  (in_valid),
        .in_method (in_method),
        .kind      (kind),
        .consume   (consume)
    );

    muc_collect #(
        .DATA_W (DATA_W),
        .REM_W  (REM_W),
        .DEPTH  (DEPTH)
    ) collect_i (
        .clk           (clk),
        .rst           (rst),
        .kind          (kind),
        .value         (in_value),
        .remaining     (in_remaining),
        .code_we       (code_we),
        .code_entry    (code_entry),
        .code_addr     (code_addr),
        .code_data     (code_data),
        .commit_valid  (commit_valid),
        .commit_entry  (commit_entry),
        .commit_count  (commit_count),
        .overflow_flag (overflow_flag),
        .orphan_flag   (orphan_flag)
    );

    // Engine path: everything except the two upload methods passes through.
    always_comb begin
        fwd_valid     = in_valid && !consume;
        fwd_method    = in_method;
        fwd_value     = in_value;
        fwd_remaining = in_remaining;
    end
endmodule

// File: rtl/macro_upload_collector_chk.sv
module macro_upload_collector_chk #(
    parameter int                  METHOD_W      = 12,
    parameter int                  CNT_W         = 7,
    parameter int                  DEPTH         = 64,
    parameter logic [METHOD_W-1:0] SELECT_METHOD = 12'h047,
    parameter logic [METHOD_W-1:0] APPEND_METHOD = 12'h046
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [METHOD_W-1:0] in_method,
    input logic                in_last,
    input logic                fwd_valid,
    input logic [METHOD_W-1:0] fwd_method,
    input logic                code_we,
    input logic                commit_valid,
    input logic [CNT_W-1:0]    commit_count,
    input logic                overflow_flag,
    input logic                orphan_flag
);
    AST_NO_FWD_UPLOAD: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (fwd_method != SELECT_METHOD && fwd_method != APPEND_METHOD)); // R6

    AST_WRITE_FROM_APPEND: assert property (@(posedge clk) disable iff (rst)
        code_we |-> $past(in_valid && in_method == APPEND_METHOD)); // R3

    AST_COMMIT_FROM_LAST: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> $past(in_valid && in_method == APPEND_METHOD && in_last)); // R4

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        commit_valid |=> !commit_valid); // R4

    AST_COMMIT_COUNT: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> (commit_count >= CNT_W'(1) && commit_count <= CNT_W'(DEPTH))); // R7

    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        overflow_flag |=> overflow_flag); // R7

    AST_NO_ORPHAN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        orphan_flag |=> orphan_flag); // R8
endmodule

bind macro_upload_collector macro_upload_collector_chk #(
    .METHOD_W      (METHOD_W),
    .CNT_W         (CNT_W),
    .DEPTH         (DEPTH),
    .SELECT_METHOD (SELECT_METHOD),
    .APPEND_METHOD (APPEND_METHOD)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_method     (in_method),
    .in_last       (in_remaining == '0),
    .fwd_valid     (fwd_valid),
    .fwd_method    (fwd_method),
    .code_we       (code_we),
    .commit_valid  (commit_valid),
    .commit_count  (commit_count),
    .overflow_flag (overflow_flag),
    .orphan_flag   (orphan_flag)
);

// File: tb/macro_upload_collector_tb_top.sv
`timescale 1ns/1ps
module macro_upload_collector_tb_top;

    localparam int WD_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_method = '0;
    logic [31:0] in_value = '0;
    logic [7:0]  in_remaining = '0;
    logic        fwd_valid;
    logic [11:0] fwd_method;
    logic [31:0] fwd_value;
    logic [7:0]  fwd_remaining;
    logic        code_we;
    logic [31:0] code_entry;
    logic [5:0]  code_addr;
    logic [31:0] code_data;
    logic        commit_valid;
    logic [31:0] commit_entry;
    logic [6:0]  commit_count;
    logic        overflow_flag;
    logic        orphan_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    macro_upload_collector dut_i (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_method (in_method),
        .in_value (in_value), .in_remaining (in_remaining),
        .fwd_valid (fwd_valid), .fwd_method (fwd_method),
        .fwd_value (fwd_value), .fwd_remaining (fwd_remaining),
        .code_we (code_we), .code_entry (code_entry),
        .code_addr (code_addr), .code_data (code_data),
        .commit_valid (commit_valid), .commit_entry (commit_entry),
        .commit_count (commit_count),
        .overflow_flag (overflow_flag), .orphan_flag (orphan_flag)
    );

    typedef struct packed {
        logic [11:0] m;
        logic [31:0] v;
        logic [7:0]  rem;
        logic        fwd;
        logic        we;
        logic [31:0] ent;
        logic [5:0]  addr;
        logic        cm;
        logic [6:0]  cnt;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{m:12'h047, v:32'h5,    rem:8'd0, fwd:0, we:0, ent:32'h0, addr:6'd0, cm:0, cnt:7'd0}, // R2 select
        '{m:12'h046, v:32'hA0,   rem:8'd2, fwd:0, we:1, ent:32'h5, addr:6'd0, cm:0, cnt:7'd0}, // R3
        '{m:12'h046, v:32'hA1,   rem:8'd1, fwd:0, we:1, ent:32'h5, addr:6'd1, cm:0, cnt:7'd0}, // R3
        '{m:12'h046, v:32'hA2,   rem:8'd0, fwd:0, we:1, ent:32'h5, addr:6'd2, cm:1, cnt:7'd3}, // R4
        '{m:12'h100, v:32'h77,   rem:8'd0, fwd:1, we:0, ent:32'h0, addr:6'd0, cm:0, cnt:7'd0}, // R6
        '{m:12'h045, v:32'h99,   rem:8'd0, fwd:1, we:0, ent:32'h0, addr:6'd0, cm:0, cnt:7'd0}, // R6 reserved
        '{m:12'h047, v:32'h9,    rem:8'd0, fwd:0, we:0, ent:32'h0, addr:6'd0, cm:0, cnt:7'd0}, // R2
        '{m:12'h046, v:32'hB0,   rem:8'd3, fwd:0, we:1, ent:32'h9, addr:6'd0, cm:0, cnt:7'd0}, // R3
        '{m:12'h047, v:32'hC,    rem:8'd0, fwd:0, we:0, ent:32'h0, addr:6'd0, cm:0, cnt:7'd0}, // R9 reselect
        '{m:12'h046, v:32'hC0,   rem:8'd0, fwd:0, we:1, ent:32'hC, addr:6'd0, cm:1, cnt:7'd1}  // R9 and R4
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one write at a falling edge, leave it for the rising edge.
    task automatic drive(input logic [11:0] m, input logic [31:0] v, input logic [7:0] r);
        @(negedge clk);
        in_valid     = 1'b1;
        in_method    = m;
        in_value     = v;
        in_remaining = r;
        #1;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(WD_CYCLES * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R1 reset state
        check(code_we == 1'b0,       "R1 code_we", 32'(code_we), 32'h0);
        check(commit_valid == 1'b0,  "R1 commit_valid", 32'(commit_valid), 32'h0);
        check(overflow_flag == 1'b0, "R1 overflow_flag", 32'(overflow_flag), 32'h0);
        check(orphan_flag == 1'b0,   "R1 orphan_flag", 32'(orphan_flag), 32'h0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].m, VECS[i].v, VECS[i].rem);
            check(fwd_valid == VECS[i].fwd, "R6 fwd_valid", 32'(fwd_valid), 32'(VECS[i].fwd));
            if (VECS[i].fwd) begin
                check(fwd_method == VECS[i].m, "R6 fwd_method", 32'(fwd_method), 32'(VECS[i].m));
                check(fwd_value == VECS[i].v, "R6 fwd_value", fwd_value, VECS[i].v);
                check(fwd_remaining == VECS[i].rem, "R6 fwd_remaining",
                      32'(fwd_remaining), 32'(VECS[i].rem));
            end
            after_edge();
            check(code_we == VECS[i].we, "R3 code_we", 32'(code_we), 32'(VECS[i].we));
            if (VECS[i].we) begin
                check(code_entry == VECS[i].ent, "R3 code_entry", code_entry, VECS[i].ent);
                check(code_addr == VECS[i].addr, "R3 R9 code_addr",
                      32'(code_addr), 32'(VECS[i].addr));
                check(code_data == VECS[i].v, "R3 code_data", code_data, VECS[i].v);
            end
            check(commit_valid == VECS[i].cm, "R4 commit_valid",
                  32'(commit_valid), 32'(VECS[i].cm));
            if (VECS[i].cm) begin
                check(commit_entry == VECS[i].ent, "R4 commit_entry", commit_entry, VECS[i].ent);
                check(commit_count == VECS[i].cnt, "R4 commit_count",
                      32'(commit_count), 32'(VECS[i].cnt));
            end
        end
        check(orphan_flag == 1'b0, "R8 no orphan yet", 32'(orphan_flag), 32'h0);

        // R5: append right after commit is dropped
        drive(12'h046, 32'hDEAD, 8'd0);
        after_edge();
        check(code_we == 1'b0,      "R5 no write after commit", 32'(code_we), 32'h0);
        check(commit_valid == 1'b0, "R5 no commit after commit", 32'(commit_valid), 32'h0);
        check(orphan_flag == 1'b1,  "R8 orphan set", 32'(orphan_flag), 32'h1);
        idle();
        after_edge();
        check(orphan_flag == 1'b1,  "R8 orphan sticky", 32'(orphan_flag), 32'h1);

        // R1: reset clears flags and leaves entry invalid
        do_reset();
        #1;
        check(orphan_flag == 1'b0, "R1 orphan cleared", 32'(orphan_flag), 32'h0);
        drive(12'h046, 32'h1234, 8'd0);
        after_edge();
        check(code_we == 1'b0,     "R1 entry invalid after reset", 32'(code_we), 32'h0);
        check(orphan_flag == 1'b1, "R1 R8 orphan after reset", 32'(orphan_flag), 32'h1);

        // R7: 70-word burst into a 64-word buffer
        do_reset();
        drive(12'h047, 32'h3, 8'd0);
        after_edge();
        for (int k = 0; k < 70; k++) begin
            drive(12'h046, 32'h1000 + 32'(k), 8'(69 - k));
            after_edge();
            check(code_we == (k < 64), "R7 write window", 32'(code_we), 32'(k < 64));
            if (k < 64 && code_we)
                check(code_addr == 6'(k), "R7 addr", 32'(code_addr), 32'(k));
            check(overflow_flag == (k >= 64), "R7 overflow_flag",
                  32'(overflow_flag), 32'(k >= 64));
            if (k == 69) begin
                check(commit_valid == 1'b1, "R7 commit", 32'(commit_valid), 32'h1);
                check(commit_count == 7'd64, "R7 commit_count", 32'(commit_count), 32'd64);
                check(commit_entry == 32'h3, "R7 commit_entry", commit_entry, 32'h3);
            end
        end
        idle();
        after_edge();
        check(overflow_flag == 1'b1, "R7 overflow sticky", 32'(overflow_flag), 32'h1);
        check(commit_valid == 1'b0,  "R4 strobe one cycle", 32'(commit_valid), 32'h0);
        check(orphan_flag == 1'b0,   "R8 no orphan in burst", 32'(orphan_flag), 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule